// File: doc/BRIEF.md
# Instruction Fetch Program Counter

This block holds the program counter of a single-cycle processor and picks the next instruction address once per clock. On every rising edge the counter moves to one of two candidates. The sequential candidate is the current address plus four. The branch candidate is that same sequential value plus a signed word offset taken from the 16-bit immediate field of the current instruction. The current address drives the instruction memory directly.

The control unit provides a branch select and a jump select. The datapath provides the ALU zero flag. A branch is taken only when the branch select and the zero flag are both high. Jump target formation is not part of this block, so an asserted jump select forces the sequential step. Ordinary arithmetic, immediate, load and store instructions hold both selects low and advance by one word.

Top module: `fetch_pc_unit`

## Requirements
- R1: When `rst` is high at a rising edge, `pc_addr` becomes 0x00000000 after that edge. Reset has priority over every select input.
- R2: When `rst`, `br_sel` and `jump_sel` are low at a rising edge, `pc_addr` becomes its old value plus 4. The values of `alu_zero` and `imm16` do not matter.
- R3: When `br_sel` is 1 and `alu_zero` is 0 at a rising edge (with `jump_sel` 0), `pc_addr` becomes its old value plus 4.
- R4: When `br_sel` and `alu_zero` are both 1 at a rising edge (with `jump_sel` 0), `pc_addr` becomes old value + 4 + (signed `imm16`) × 4.
- R5: `imm16` is read as two's complement, with bit 15 as the sign. The offset is the immediate followed by two zero bits, sign-extended to 32 bits. It spans -0x20000 to +0x1FFFC bytes from the sequential address.
- R6: The two low bits of `pc_addr` are always 00.
- R7: All address arithmetic wraps modulo 2^32, in both the forward and the backward direction.
- R8: When `jump_sel` is 1 at a rising edge, `pc_addr` becomes its old value plus 4, whatever the values of `br_sel`, `alu_zero` and `imm16`.
- R9: `pc_addr` changes only at a rising edge of `clk`. It holds its value between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset to address zero |
| br_sel | input | 1 | Branch select from the control unit |
| alu_zero | input | 1 | ALU zero flag, the branch condition |
| jump_sel | input | 1 | Jump select; forces the sequential step |
| imm16 | input | 16 | Signed word offset field of the current instruction |
| pc_addr | output | 32 | Current word-aligned instruction address |

## Verification
The clocked properties assume that the select inputs, the zero flag and the immediate are settled, 0 or 1, at every rising edge. They also assume that reset is high at the first edge, so the counter has a known value before any step is compared with its previous value. The stimulus meets both conditions. It drives all inputs on the falling edge only, and it holds reset from time zero through the first rising edges. The wrap cases start from that known zero and branch backwards past it, so they test the modular arithmetic without loading the counter with an arbitrary value.

// File: rtl/fetch_pc_pkg.sv
package fetch_pc_pkg;

    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned OFS_W    = 16;
    localparam int unsigned WORD_B   = 4;
    localparam int unsigned ALIGN_W  = $clog2(WORD_B);
    localparam int unsigned SCALED_W = OFS_W + ALIGN_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [OFS_W-1:0]  ofs_t;

    typedef enum logic [0:0] {
        PATH_SEQ = 1'b0,
        PATH_BR  = 1'b1
    } path_e;

    typedef struct packed {
        addr_t seq;
        addr_t tgt;
    } cand_t;

    typedef struct packed {
        logic br;
        logic zero;
        logic jmp;
    } ctl_t;

    function automatic addr_t scale_offset(input ofs_t raw);
        logic [SCALED_W-1:0] shifted;
        shifted = {raw, {ALIGN_W{1'b0}}};
        return {{(ADDR_W-SCALED_W){shifted[SCALED_W-1]}}, shifted};
    endfunction

    function automatic path_e choose_path(input ctl_t c);
        if (c.jmp)
            return PATH_SEQ;
        if (c.br && c.zero)
            return PATH_BR;
        return PATH_SEQ;
    endfunction

endpackage

// File: rtl/fetch_pc_seq_add.sv
module fetch_pc_seq_add
    import fetch_pc_pkg::*;
(
    input  addr_t cur_addr,
    output addr_t seq_addr
);
    localparam addr_t STEP = addr_t'(WORD_B);

    always_comb begin
        seq_addr = cur_addr + STEP;
    end
endmodule

// File: rtl/fetch_pc_tgt_add.sv
module fetch_pc_tgt_add
    import fetch_pc_pkg::*;
(
    input  addr_t seq_addr,
    input  ofs_t  raw_ofs,
    output addr_t tgt_addr
);
    addr_t ofs_ext;

    always_comb begin
        ofs_ext  = scale_offset(raw_ofs);
        tgt_addr = seq_addr + ofs_ext;
    end
endmodule

// File: rtl/fetch_pc_select.sv
module fetch_pc_select
    import fetch_pc_pkg::*;
(
    input  ctl_t  ctl,
    input  cand_t cand,
    output addr_t next_addr
);
    path_e path;

    always_comb begin
        path = choose_path(ctl);
        unique case (path)
            PATH_BR:  next_addr = cand.tgt;
            default:  next_addr = cand.seq;
        endcase
    end
endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
    import fetch_pc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              br_sel,
    input  logic              alu_zero,
    input  logic              jump_sel,
    input  logic [OFS_W-1:0]  imm16,
    output logic [ADDR_W-1:0] pc_addr
);
    localparam addr_t RESET_ADDR = '0;

    addr_t pc_q;
    addr_t next_addr;
    cand_t cand;
    ctl_t  ctl;

    assign ctl = '{br: br_sel, zero: alu_zero, jmp: jump_sel};

    fetch_pc_seq_add u_seq (
        .cur_addr (pc_q),
        .seq_addr (cand.seq)
    );

    fetch_pc_tgt_add u_tgt (
        .seq_addr (cand.seq),
        .raw_ofs  (imm16),
        .tgt_addr (cand.tgt)
    );

    fetch_pc_select u_sel (
        .ctl       (ctl),
        .cand      (cand),
        .next_addr (next_addr)
    );

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= RESET_ADDR;
        else
            pc_q <= next_addr;
    end

    assign pc_addr = pc_q;
endmodule

// File: rtl/fetch_pc_unit_chk.sv
module fetch_pc_unit_chk
    import fetch_pc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              br_sel,
    input logic              alu_zero,
    input logic              jump_sel,
    input logic [OFS_W-1:0]  imm16,
    input logic [ADDR_W-1:0] pc_addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_B);

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (pc_addr == '0));                                                          // R1

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (!br_sel && !jump_sel) |=> (pc_addr == $past(pc_addr) + STEP));                    // R2

    AST_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (br_sel && !alu_zero && !jump_sel) |=> (pc_addr == $past(pc_addr) + STEP));        // R3

    AST_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (br_sel && alu_zero && !jump_sel) |=>
        (pc_addr == $past(pc_addr) + STEP
            + {{(ADDR_W-OFS_W-ALIGN_W){$past(imm16[OFS_W-1])}}, $past(imm16), {ALIGN_W{1'b0}}}));  // R4

    AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        pc_addr[ALIGN_W-1:0] == '0);                                                       // R6

    AST_JUMP_SEQ: assert property (@(posedge clk) disable iff (rst)
        jump_sel |=> (pc_addr == $past(pc_addr) + STEP));                                  // R8
endmodule

bind fetch_pc_unit fetch_pc_unit_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .br_sel   (br_sel),
    .alu_zero (alu_zero),
    .jump_sel (jump_sel),
    .imm16    (imm16),
    .pc_addr  (pc_addr)
);

// File: tb/fetch_pc_unit_tb_top.sv
`timescale 1ns/1ps
module fetch_pc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_sel = 1'b0;
    logic        alu_zero = 1'b0;
    logic        jump_sel = 1'b0;
    logic [15:0] imm16 = '0;
    logic [31:0] pc_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    fetch_pc_unit dut_i (
        .clk      (clk),
        .rst      (rst),
        .br_sel   (br_sel),
        .alu_zero (alu_zero),
        .jump_sel (jump_sel),
        .imm16    (imm16),
        .pc_addr  (pc_addr)
    );

    // {br, zero, imm16, expected address after the edge}
    localparam int NV = 10;
    localparam logic [49:0] VEC [NV] = '{
        {1'b0, 1'b0, 16'h0010, 32'h0000_0004},  // R2
        {1'b0, 1'b1, 16'h0010, 32'h0000_0008},  // R2 zero ignored
        {1'b1, 1'b0, 16'h0010, 32'h0000_000C},  // R3
        {1'b1, 1'b1, 16'h0010, 32'h0000_0050},  // R4
        {1'b1, 1'b1, 16'hFFFF, 32'h0000_0050},  // R5 -1 word
        {1'b1, 1'b1, 16'hFFFE, 32'h0000_004C},  // R5 -2 words
        {1'b1, 1'b1, 16'h7FFF, 32'h0002_004C},  // R5 max forward
        {1'b1, 1'b1, 16'h8000, 32'h0000_0050},  // R5 max backward
        {1'b0, 1'b1, 16'h8000, 32'h0000_0054},  // R2
        {1'b1, 1'b1, 16'h0000, 32'h0000_0058}   // R4 zero offset
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic step(input logic b, input logic z, input logic j, input logic [15:0] im,
                        input logic [31:0] exp, input string req);
        br_sel = b; alu_zero = z; jump_sel = j; imm16 = im;
        @(negedge clk);
        check(req, pc_addr, exp);
        check("R6", {30'd0, pc_addr[1:0]}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", pc_addr, 32'h0);
        rst = 1'b0;
        for (int i = 0; i < NV; i++)
            step(VEC[i][49], VEC[i][48], 1'b0, VEC[i][47:32], VEC[i][31:0], "R2/R3/R4/R5 table");

        // R9: hold between edges
        @(posedge clk); #1;
        begin
            logic [31:0] held;
            held = pc_addr;
            #2;
            check("R9", pc_addr, held);
        end
        @(negedge clk);  // now 0x60 after the extra edge
        check("R2", pc_addr, 32'h0000_0060);

        // R8: jump forces sequential even with taken branch
        step(1'b1, 1'b1, 1'b1, 16'h0100, 32'h0000_0064, "R8");
        step(1'b0, 1'b0, 1'b1, 16'hFFFF, 32'h0000_0068, "R8");

        // R1: reset has priority over a taken branch
        rst = 1'b1;
        step(1'b1, 1'b1, 1'b0, 16'h0040, 32'h0000_0000, "R1");
        rst = 1'b0;

        // R7: backward wrap below zero, then forward wrap
        step(1'b1, 1'b1, 1'b0, 16'hFFFE, 32'hFFFF_FFFC, "R7");
        step(1'b0, 1'b0, 1'b0, 16'h0000, 32'h0000_0000, "R7");
        step(1'b1, 1'b1, 1'b0, 16'hFFFC, 32'hFFFF_FFF4, "R7");
        step(1'b1, 1'b1, 1'b0, 16'h0002, 32'h0000_0000, "R7");
        step(1'b1, 1'b0, 1'b0, 16'h7FFF, 32'h0000_0004, "R3");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule